// File: doc/BRIEF.md
# Stack and Context-Save Sequencer

This block is the stack engine of a small 8-bit processor with a 256-byte data space and a 256-byte program space. It holds the 8-bit stack pointer and turns stack commands into data-memory cycles, register-file write-backs and program-counter loads. The commands are: push and pop of one register, call and return, soft reset, and a multi-cycle save and restore of the processor context. The context is the flag byte plus registers 0 to 3 of bank 0.

A command is offered with `cmd_valid` while the block is idle. From the next cycle `busy` is high, and the block drives one stack access per cycle. `done` is high during the final busy cycle. Single-byte commands take one busy cycle, save takes six and restore takes five. The register file and the data memory sit outside the block, and both are read combinationally: the read address goes out and the read data comes back in the same cycle. The stack grows downward. Push pre-decrements the pointer and pop post-increments it, and the pointer wraps modulo 256.

Top module: `stack_ctx_seq`

## Requirements
- R1: After reset, `sp` is 0x00, `busy` and `done` are low, and no write strobe (`mem_we`, `rf_we`, `rf_clr_bank0`, `flags_we`, `pc_load`) is asserted while idle.
- R2: Push (cmd_op 3'd1) writes register `cmd_reg` to data address sp-1 and leaves sp decremented by one. The first push after reset therefore writes address 0xFF.
- R3: Pop (cmd_op 3'd2) loads register `cmd_reg` from data address sp and leaves sp incremented by one.
- R4: Call (cmd_op 3'd3) writes `pc_in` to address sp-1, decrements sp, and loads the PC with `cmd_imm`.
- R5: Return (cmd_op 3'd4) loads the PC with the byte at address sp and increments sp.
- R6: Soft reset (cmd_op 3'd5) sets sp to 0x00 and loads the PC with 0x00.
- R7: Save (cmd_op 3'd6) writes the flag byte to sp-1, then registers 0, 1, 2, 3 (register index bit 2 = bank, so always bank 0) to sp-2 through sp-5. It then clears those four registers in one cycle with `rf_clr_bank0`. It leaves sp lowered by 5.
- R8: Restore (cmd_op 3'd7) pops registers 3, 2, 1, 0 of bank 0 in that order and then pops the flag byte. It leaves sp raised by 5, so a restore right after a save returns the saved values exactly.
- R9: `busy` is high for exactly 1 cycle for push, pop, call, return and soft reset, 6 cycles for save and 5 for restore. `done` is a one-cycle pulse in the last busy cycle.
- R10: `cmd_valid` while busy, and cmd_op 3'd0 at any time, have no effect on sp, memory, registers, flags or PC.
- R11: sp wraps modulo 256 in both directions: a pop at sp 0xFF reads address 0xFF and leaves sp at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 3 | Command code |
| cmd_reg | input | 3 | Register index for push/pop (bit 2 = bank) |
| cmd_imm | input | 8 | Call target |
| pc_in | input | 8 | Current program counter |
| flags_in | input | 8 | Current flag byte |
| rf_rdata | input | 8 | Register-file read data for `rf_raddr` |
| mem_rdata | input | 8 | Data-memory read data for `mem_addr` |
| rf_raddr | output | 3 | Register-file read index |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 8 | Register write data |
| rf_clr_bank0 | output | 1 | Clear registers 0-3 of bank 0 |
| flags_we | output | 1 | Flag byte write enable |
| flags_wdata | output | 8 | Flag byte write data |
| pc_load | output | 1 | PC load strobe |
| pc_value | output | 8 | Value loaded into the PC |
| mem_addr | output | 8 | Data-memory address |
| mem_wdata | output | 8 | Data-memory write data |
| mem_we | output | 1 | Data-memory write enable |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last cycle of a command |

## Verification
The bench targets the pointer wrap at both ends. A design that post-decrements, or that forgets the wrap, would write the first push to 0x00 or pop from the wrong byte. It runs a save followed by a restore with distinct register and flag values. An ordering slip or an off-by-one in the frame layout would swap registers or put a register value into the flags. It also issues commands during a save and uses the idle opcode. A block that accepted either one would corrupt memory or move sp. Random push/pop/call/return streams, with changing register and flag contents, are compared against a model kept in the bench.

// File: rtl/stack_ctx_seq.sv
module stack_ctx_seq #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [RW-1:0] cmd_reg,
  input  logic [AW-1:0] cmd_imm,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] flags_in,
  input  logic [DW-1:0] rf_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [RW-1:0] rf_raddr,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_clr_bank0,
  output logic          flags_we,
  output logic [DW-1:0] flags_wdata,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic [AW-1:0] sp,
  output logic          busy,
  output logic          done
);
  localparam logic [2:0] OP_PUSH = 3'd1, OP_POP = 3'd2, OP_CALL = 3'd3,
                         OP_RET  = 3'd4, OP_RSET = 3'd5, OP_SAVE = 3'd6,
                         OP_RSTR = 3'd7;
  localparam int NREG = 4;
  localparam logic [2:0] SAVE_LAST = 3'(NREG + 1);
  localparam logic [2:0] RSTR_LAST = 3'(NREG);

  logic          busy_q;
  logic [2:0]    op_q;
  logic [RW-1:0] reg_q;
  logic [AW-1:0] imm_q;
  logic [2:0]    step_q;
  logic [AW-1:0] sp_q;
  logic          last, sp_inc;

  assign busy = busy_q;
  assign sp   = sp_q;
  assign last = (op_q == OP_SAVE) ? (step_q == SAVE_LAST) :
                (op_q == OP_RSTR) ? (step_q == RSTR_LAST) : 1'b1;
  assign done = busy_q && last;
  assign sp_inc = busy_q && (op_q == OP_POP || op_q == OP_RET || op_q == OP_RSTR);

  always_comb begin
    rf_raddr     = reg_q;
    rf_we        = 1'b0;
    rf_waddr     = reg_q;
    rf_wdata     = mem_rdata;
    rf_clr_bank0 = 1'b0;
    flags_we     = 1'b0;
    flags_wdata  = mem_rdata;
    pc_load      = 1'b0;
    pc_value     = AW'(mem_rdata);
    mem_addr     = sp_q;
    mem_wdata    = rf_rdata;
    mem_we       = 1'b0;
    if (busy_q) begin
      case (op_q)
        OP_PUSH: begin
          mem_addr = sp_q - 1'b1;
          mem_we   = 1'b1;
        end
        OP_POP: rf_we = 1'b1;
        OP_CALL: begin
          mem_addr  = sp_q - 1'b1;
          mem_wdata = DW'(pc_in);
          mem_we    = 1'b1;
          pc_load   = 1'b1;
          pc_value  = imm_q;
        end
        OP_RET: pc_load = 1'b1;
        OP_RSET: begin
          pc_load  = 1'b1;
          pc_value = '0;
        end
        OP_SAVE: begin
          mem_addr = sp_q - 1'b1;
          rf_raddr = RW'(step_q - 3'd1);
          if (step_q == 3'd0) begin
            mem_wdata = flags_in;
            mem_we    = 1'b1;
          end else if (step_q == SAVE_LAST) begin
            rf_clr_bank0 = 1'b1;
          end else begin
            mem_we = 1'b1;
          end
        end
        OP_RSTR: begin
          rf_waddr = RW'(3'(NREG - 1) - step_q);
          if (step_q == RSTR_LAST) flags_we = 1'b1;
          else                     rf_we    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      reg_q  <= '0;
      imm_q  <= '0;
      step_q <= '0;
      sp_q   <= '0;
    end else begin
      if (!busy_q) begin
        if (cmd_valid && cmd_op != 3'd0) begin
          busy_q <= 1'b1;
          op_q   <= cmd_op;
          reg_q  <= cmd_reg;
          imm_q  <= cmd_imm;
          step_q <= '0;
        end
      end else begin
        step_q <= step_q + 3'd1;
        if (last) busy_q <= 1'b0;
      end
      if (busy_q && op_q == OP_RSET) sp_q <= '0;
      else if (mem_we)               sp_q <= sp_q - 1'b1;
      else if (sp_inc)               sp_q <= sp_q + 1'b1;
    end
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || rf_we || rf_clr_bank0 || flags_we || pc_load)); // R1
  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_PUSH) |-> (mem_addr == sp - 1'b1) ##1 (sp == $past(sp) - 1'b1)); // R2
  AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_POP) |=> (sp == $past(sp) + 1'b1)); // R3
  AST_RSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_RSET) |=> (sp == '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R9
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R9
  AST_BUSY_STABLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy && $stable(op_q)); // R10
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_we, rf_we, flags_we, rf_clr_bank0}) <= 1); // R7
endmodule

// File: tb/tb_stack_ctx_seq.sv
module tb_stack_ctx_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0, cmd_reg = '0;
  logic [7:0] cmd_imm = '0;
  logic [7:0] rf_rdata, mem_rdata, flags_in, pc_in;
  logic [2:0] rf_raddr, rf_waddr;
  logic rf_we, rf_clr_bank0, flags_we, pc_load, mem_we, busy, done;
  logic [7:0] rf_wdata, flags_wdata, pc_value, mem_addr, mem_wdata, sp;

  logic [7:0] mem [256];
  logic [7:0] rf [8];
  logic [7:0] flags, pc;
  logic [7:0] e_mem [256];
  logic [7:0] e_rf [8];
  logic [7:0] e_flags, e_pc, e_sp;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  stack_ctx_seq dut (.*);

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr];
  assign flags_in  = flags;
  assign pc_in     = pc;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (rf_clr_bank0) for (int i = 0; i < 4; i++) rf[i] <= 8'h00;
    if (flags_we) flags <= flags_wdata;
    if (pc_load) pc <= pc_value;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int bad;
    chk({tag, " sp"}, sp, e_sp);
    chk({tag, " pc"}, pc, e_pc);
    chk({tag, " flags"}, flags, e_flags);
    bad = 0;
    for (int i = 0; i < 8; i++) if (rf[i] !== e_rf[i]) bad++;
    chk({tag, " regfile mismatches"}, bad, 0);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== e_mem[i]) bad++;
    chk({tag, " memory mismatches"}, bad, 0);
  endtask

  function automatic int cycles_for(input logic [2:0] op);
    return (op == 3'd6) ? 6 : (op == 3'd7) ? 5 : 1;
  endfunction

  task automatic model(input logic [2:0] op, input logic [2:0] r, input logic [7:0] imm);
    case (op)
      3'd1: begin e_sp = e_sp - 1; e_mem[e_sp] = e_rf[r]; end
      3'd2: begin e_rf[r] = e_mem[e_sp]; e_sp = e_sp + 1; end
      3'd3: begin e_sp = e_sp - 1; e_mem[e_sp] = e_pc; e_pc = imm; end
      3'd4: begin e_pc = e_mem[e_sp]; e_sp = e_sp + 1; end
      3'd5: begin e_sp = 0; e_pc = 0; end
      3'd6: begin
        e_sp = e_sp - 1; e_mem[e_sp] = e_flags;
        for (int i = 0; i < 4; i++) begin e_sp = e_sp - 1; e_mem[e_sp] = e_rf[i]; end
        for (int i = 0; i < 4; i++) e_rf[i] = 0;
      end
      3'd7: begin
        for (int i = 3; i >= 0; i--) begin e_rf[i] = e_mem[e_sp]; e_sp = e_sp + 1; end
        e_flags = e_mem[e_sp]; e_sp = e_sp + 1;
      end
      default: ;
    endcase
  endtask

  task automatic run(input logic [2:0] op, input logic [2:0] r, input logic [7:0] imm,
                     input string tag, input bit intrude);
    int cyc, n;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_reg = r; cmd_imm = imm;
    @(negedge clk);
    cmd_valid = 0;
    cyc = 0; n = 0;
    forever begin
      if (busy) cyc++;
      if (done || n > 20) break;
      n++;
      if (intrude && n == 1) begin cmd_valid = 1; cmd_op = 3'd1; cmd_reg = 3'd5; end
      else cmd_valid = 0;
      @(negedge clk);
    end
    cmd_valid = 0;
    @(negedge clk);
    chk({tag, " R9 busy cycles"}, cyc, cycles_for(op));
    chk({tag, " R9 done one pulse"}, {busy, done}, 2'b00);
    model(op, r, imm);
    compare_all(tag);
  endtask

  task automatic set_rf(input int i, input logic [7:0] v);
    @(negedge clk); rf[i] = v; e_rf[i] = v;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i ^ 8'h5A); e_mem[i] = mem[i]; end
    for (int i = 0; i < 8; i++) begin rf[i] = 8'(8'h10 + i); e_rf[i] = rf[i]; end
    flags = 8'hC3; e_flags = flags; pc = 8'h40; e_pc = pc; e_sp = 0;
    repeat (3) @(negedge clk);
    chk("R1 sp after reset", sp, 8'h00);
    chk("R1 busy/done after reset", {busy, done}, 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle no strobes", {mem_we, rf_we, rf_clr_bank0, flags_we, pc_load}, 5'b0);

    run(3'd1, 3'd2, 8'h00, "R2 first push", 0);
    chk("R2 first push to 0xFF", mem[8'hFF], 8'h12);
    run(3'd2, 3'd6, 8'h00, "R3 pop", 0);
    chk("R3 pop value", rf[6], 8'h12);
    run(3'd3, 3'd0, 8'h9C, "R4 call", 0);
    chk("R4 pc target", pc, 8'h9C);
    chk("R4 pushed pc", mem[8'hFF], 8'h40);
    run(3'd4, 3'd0, 8'h00, "R5 ret", 0);
    chk("R5 pc restored", pc, 8'h40);
    run(3'd2, 3'd1, 8'h00, "R11 pop at 0 ", 0);
    run(3'd5, 3'd0, 8'h00, "R6 rset", 0);
    run(3'd1, 3'd7, 8'h00, "R11 push wrap", 0);
    chk("R11 sp 0xFF", sp, 8'hFF);
    run(3'd2, 3'd3, 8'h00, "R11 pop at FF", 0);
    chk("R11 sp wraps to 0", sp, 8'h00);

    set_rf(0, 8'hA0); set_rf(1, 8'hB1); set_rf(2, 8'hC2); set_rf(3, 8'hD3);
    @(negedge clk); flags = 8'h5E; e_flags = 8'h5E;
    run(3'd6, 3'd0, 8'h00, "R7 save", 0);
    chk("R7 flag first", mem[8'hFF], 8'h5E);
    chk("R7 R3 last", mem[8'hFB], 8'hD3);
    chk("R7 regs cleared", {rf[0], rf[1], rf[2], rf[3]}, 32'h0);
    @(negedge clk); flags = 8'h00; e_flags = 8'h00;
    run(3'd7, 3'd0, 8'h00, "R8 restore", 0);
    chk("R8 R0 back", rf[0], 8'hA0);
    chk("R8 flags back", flags, 8'h5E);
    chk("R8 sp back", sp, 8'h00);

    run(3'd6, 3'd0, 8'h00, "R10 save with intrusion", 1);
    @(negedge clk); cmd_valid = 1; cmd_op = 3'd0;
    @(negedge clk); cmd_valid = 0;
    chk("R10 op0 not busy", busy, 1'b0);
    repeat (2) @(negedge clk);
    compare_all("R10 op0 ignored");
    run(3'd7, 3'd0, 8'h00, "R8 restore after intrusion", 0);

    for (int k = 0; k < 400; k++) begin
      int sel;
      logic [2:0] op;
      sel = $urandom_range(0, 9);
      if (sel == 0) begin @(negedge clk); flags = 8'($urandom); e_flags = flags; end
      if (sel == 1) set_rf($urandom_range(0, 7), 8'($urandom));
      op = (sel < 4) ? 3'd1 : (sel < 6) ? 3'd2 : (sel == 6) ? 3'd3 : (sel == 7) ? 3'd4 :
           (sel == 8) ? 3'd6 : 3'd7;
      run(op, 3'($urandom), 8'($urandom), "R2-mix random", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule